// File: doc/BRIEF.md
# Split-Cache Self-Modifying Code Snoop Controller

This controller watches for code that writes its own instructions. It receives miss events from both halves of a split cache and takes them one at a time. For each miss it queries the structures on the opposite side. A data miss looks at the instruction-side structures: the instruction cache, the prefetch cache and the line-fill buffer. An instruction miss looks at the data-side structures: the data cache, the store buffer and the writeback buffer. The controller then issues the matching actions and ends with a done pulse. That pulse carries an action code, which tells the requesting side what to do with the original access.

Both lookups are simple request/response ports. The controller drives a probe strobe and a line address. In the same cycle the cache side answers with one hit bit per structure, and on the data side also one modified bit per structure. A modified data-side line is written back through a request/acknowledge pair. The written-back line is then forwarded straight to the instruction side, so no separate line fill is needed. Hits in the cache that missed itself never reach this block.

Top module: `smc_snoop_ctrl`

## Requirements
- R1: When a data miss and an instruction miss are both valid in an idle cycle, only the data miss is acknowledged. The instruction miss is acknowledged only after the data miss has produced its done pulse.
- R2: A data miss (read or write) is acknowledged only in an idle cycle. In the cycle after acknowledge it asserts `probe_i_valid_o` for exactly one cycle, with `probe_addr_o` equal to the miss address, and `probe_d_valid_o` stays low.
- R3: A data read miss whose probe finds a hit in any instruction-side structure invalidates nothing. Its done pulse comes one cycle after the probe, with action code 1 (retry as single non-cacheable read).
- R4: A data write miss whose probe hits issues `ivict_o` for one cycle, in the cycle after the probe, with `ivict_mask_o` equal to the hit vector. The done pulse follows in the next cycle with action code 0 (proceed).
- R5: An instruction miss asserts `probe_d_valid_o` for exactly one cycle, in the cycle after acknowledge, with its address. `probe_i_valid_o` stays low.
- R6: An instruction miss that hits a data-side structure whose modified bit is set runs a fixed sequence. It raises `wb_req_o` and holds it until `wb_ack_i`. In the next cycle it presents the captured `wb_data_i` on `fwd_data_o` with `fwd_valid_o` for one cycle. In the cycle after that it pulses `dinv_o` with the hit vector. The done pulse follows with action code 3 (forwarded).
- R7: An instruction miss that hits only unmodified data-side lines never raises `wb_req_o`. A modified bit on a structure that did not hit counts as clean. The miss pulses `dinv_o` with the hit vector in the cycle after the probe, and the done pulse follows with action code 2 (retry cached).
- R8: When the probe misses every structure, no invalidate, writeback or forward is issued. The done pulse comes one cycle after the probe with action code 0 (proceed).
- R9: `done_o` lasts exactly one cycle. `done_addr_o` echoes the miss address, and `done_src_o` is 0 for a data miss and 1 for an instruction miss.
- R10: After reset `done_o`, both probe strobes, `ivict_o`, `wb_req_o`, `fwd_valid_o` and `dinv_o` are low.
- R11: While a miss is being resolved, neither miss input is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dmiss_valid_i | input | 1 | Data-cache miss pending |
| dmiss_write_i | input | 1 | Data miss is a write (1) or read (0) |
| dmiss_addr_i | input | ADDR_W | Data miss line address |
| dmiss_ack_o | output | 1 | Data miss accepted this cycle |
| imiss_valid_i | input | 1 | Instruction-cache miss pending |
| imiss_addr_i | input | ADDR_W | Instruction miss line address |
| imiss_ack_o | output | 1 | Instruction miss accepted this cycle |
| probe_i_valid_o | output | 1 | Probe of instruction-side structures |
| probe_d_valid_o | output | 1 | Probe of data-side structures |
| probe_addr_o | output | ADDR_W | Line address being probed |
| isnp_hit_i | input | N_STRUCT | Hit per instruction-side structure (cache, prefetch, fill buffer) |
| dsnp_hit_i | input | N_STRUCT | Hit per data-side structure (cache, store buffer, writeback buffer) |
| dsnp_mod_i | input | N_STRUCT | Modified flag per data-side structure |
| ivict_o | output | 1 | Invalidate instruction-side line |
| ivict_mask_o | output | N_STRUCT | Instruction-side structures to invalidate |
| wb_req_o | output | 1 | Write back modified data-side line |
| wb_addr_o | output | ADDR_W | Writeback line address |
| wb_ack_i | input | 1 | Writeback finished, data valid |
| wb_data_i | input | LINE_W | Written-back line data |
| fwd_valid_o | output | 1 | Forward line to instruction cache |
| fwd_addr_o | output | ADDR_W | Forwarded line address |
| fwd_data_o | output | LINE_W | Forwarded line data |
| dinv_o | output | 1 | Invalidate data-side line |
| dinv_mask_o | output | N_STRUCT | Data-side structures to invalidate |
| done_o | output | 1 | Resolution complete (one cycle) |
| done_action_o | output | 2 | 0 proceed, 1 retry non-cacheable, 2 retry cached, 3 forwarded |
| done_src_o | output | 1 | 0 data miss, 1 instruction miss |
| done_addr_o | output | ADDR_W | Address of the resolved miss |

## Verification
The one collision this block has to settle is a data miss and an instruction miss arriving in the same idle cycle. Both miss inputs are raised on the same edge, and the acknowledge outputs are sampled right away: only the data side may be accepted. The instruction miss is then held valid. The bench records the cycle in which it is finally accepted and compares it with the cycle of the first done pulse. It also checks that the two done pulses report the data source first and the instruction source second.

// File: rtl/smc_snoop_pkg.sv
package smc_snoop_pkg;
  localparam int unsigned N_STRUCT = 3;

  typedef enum logic [1:0] {
    ACT_PROCEED      = 2'd0,
    ACT_RETRY_NC     = 2'd1,
    ACT_RETRY_CACHED = 2'd2,
    ACT_FORWARDED    = 2'd3
  } snp_act_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PROBE_I, S_PROBE_D, S_INV_I, S_WB, S_FWD, S_INV_D, S_FIN
  } snp_state_e;

  typedef enum logic [1:0] {
    K_DRD, K_DWR, K_IRD
  } miss_kind_e;
endpackage

// File: rtl/smc_miss_arb.sv
module smc_miss_arb
  import smc_snoop_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              idle_i,
  input  logic              dmiss_valid_i,
  input  logic              dmiss_write_i,
  input  logic [ADDR_W-1:0] dmiss_addr_i,
  input  logic              imiss_valid_i,
  input  logic [ADDR_W-1:0] imiss_addr_i,
  output logic              dack_o,
  output logic              iack_o,
  output logic              grant_o,
  output miss_kind_e        kind_o,
  output logic [ADDR_W-1:0] addr_o
);
  // data side wins a same-cycle collision
  assign dack_o  = idle_i & dmiss_valid_i;
  assign iack_o  = idle_i & imiss_valid_i & ~dmiss_valid_i;
  assign grant_o = dack_o | iack_o;

  always_comb begin
    if (dmiss_valid_i) begin
      kind_o = dmiss_write_i ? K_DWR : K_DRD;
      addr_o = dmiss_addr_i;
    end else begin
      kind_o = K_IRD;
      addr_o = imiss_addr_i;
    end
  end
endmodule

// File: rtl/smc_probe_eval.sv
module smc_probe_eval #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] isnp_hit_i,
  input  logic [N-1:0] dsnp_hit_i,
  input  logic [N-1:0] dsnp_mod_i,
  output logic         i_any_o,
  output logic         d_any_o,
  output logic         d_dirty_o
);
  logic [N-1:0] dirty_vec;

  // a modified flag only counts where the structure also hits
  for (genvar g = 0; g < N; g++) begin : g_dirty
    assign dirty_vec[g] = dsnp_hit_i[g] & dsnp_mod_i[g];
  end

  assign i_any_o   = |isnp_hit_i;
  assign d_any_o   = |dsnp_hit_i;
  assign d_dirty_o = |dirty_vec;
endmodule

// File: rtl/smc_seq_fsm.sv
module smc_seq_fsm
  import smc_snoop_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 256,
  parameter int unsigned N      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  miss_kind_e        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              i_any_i,
  input  logic              d_any_i,
  input  logic              d_dirty_i,
  input  logic [N-1:0]      isnp_hit_i,
  input  logic [N-1:0]      dsnp_hit_i,
  input  logic              wb_ack_i,
  input  logic [LINE_W-1:0] wb_data_i,
  output logic              idle_o,
  output logic              probe_i_valid_o,
  output logic              probe_d_valid_o,
  output logic [ADDR_W-1:0] probe_addr_o,
  output logic              ivict_o,
  output logic [N-1:0]      ivict_mask_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic              fwd_valid_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic [LINE_W-1:0] fwd_data_o,
  output logic              dinv_o,
  output logic [N-1:0]      dinv_mask_o,
  output logic              done_o,
  output logic [1:0]        done_action_o,
  output logic              done_src_o,
  output logic [ADDR_W-1:0] done_addr_o
);
  snp_state_e        state_q, state_d;
  miss_kind_e        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [N-1:0]      mask_q;
  snp_act_e          act_q, act_d;
  logic [LINE_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    act_d   = act_q;
    unique case (state_q)
      S_IDLE: if (grant_i) state_d = (kind_i == K_IRD) ? S_PROBE_D : S_PROBE_I;
      S_PROBE_I: begin
        if (!i_any_i) begin
          state_d = S_FIN;
          act_d   = ACT_PROCEED;
        end else if (kind_q == K_DWR) begin
          state_d = S_INV_I;
          act_d   = ACT_PROCEED;
        end else begin
          state_d = S_FIN;
          act_d   = ACT_RETRY_NC;
        end
      end
      S_PROBE_D: begin
        if (!d_any_i) begin
          state_d = S_FIN;
          act_d   = ACT_PROCEED;
        end else if (d_dirty_i) begin
          state_d = S_WB;
          act_d   = ACT_FORWARDED;
        end else begin
          state_d = S_INV_D;
          act_d   = ACT_RETRY_CACHED;
        end
      end
      S_INV_I: state_d = S_FIN;
      S_WB:    if (wb_ack_i) state_d = S_FWD;
      S_FWD:   state_d = S_INV_D;
      S_INV_D: state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_DRD;
      addr_q  <= '0;
      mask_q  <= '0;
      act_q   <= ACT_PROCEED;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      if (state_q == S_IDLE && grant_i) begin
        kind_q <= kind_i;
        addr_q <= addr_i;
      end
      if (state_q == S_PROBE_I) mask_q <= isnp_hit_i;
      if (state_q == S_PROBE_D) mask_q <= dsnp_hit_i;
      if (state_q == S_WB && wb_ack_i) data_q <= wb_data_i;
    end
  end

  assign idle_o          = (state_q == S_IDLE);
  assign probe_i_valid_o = (state_q == S_PROBE_I);
  assign probe_d_valid_o = (state_q == S_PROBE_D);
  assign probe_addr_o    = addr_q;
  assign ivict_o         = (state_q == S_INV_I);
  assign ivict_mask_o    = mask_q;
  assign wb_req_o        = (state_q == S_WB);
  assign wb_addr_o       = addr_q;
  assign fwd_valid_o     = (state_q == S_FWD);
  assign fwd_addr_o      = addr_q;
  assign fwd_data_o      = data_q;
  assign dinv_o          = (state_q == S_INV_D);
  assign dinv_mask_o     = mask_q;
  assign done_o          = (state_q == S_FIN);
  assign done_action_o   = act_q;
  assign done_src_o      = (kind_q == K_IRD);
  assign done_addr_o     = addr_q;
endmodule

// File: rtl/smc_snoop_ctrl.sv
module smc_snoop_ctrl
  import smc_snoop_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dmiss_valid_i,
  input  logic                dmiss_write_i,
  input  logic [ADDR_W-1:0]   dmiss_addr_i,
  output logic                dmiss_ack_o,
  input  logic                imiss_valid_i,
  input  logic [ADDR_W-1:0]   imiss_addr_i,
  output logic                imiss_ack_o,
  output logic                probe_i_valid_o,
  output logic                probe_d_valid_o,
  output logic [ADDR_W-1:0]   probe_addr_o,
  input  logic [N_STRUCT-1:0] isnp_hit_i,
  input  logic [N_STRUCT-1:0] dsnp_hit_i,
  input  logic [N_STRUCT-1:0] dsnp_mod_i,
  output logic                ivict_o,
  output logic [N_STRUCT-1:0] ivict_mask_o,
  output logic                wb_req_o,
  output logic [ADDR_W-1:0]   wb_addr_o,
  input  logic                wb_ack_i,
  input  logic [LINE_W-1:0]   wb_data_i,
  output logic                fwd_valid_o,
  output logic [ADDR_W-1:0]   fwd_addr_o,
  output logic [LINE_W-1:0]   fwd_data_o,
  output logic                dinv_o,
  output logic [N_STRUCT-1:0] dinv_mask_o,
  output logic                done_o,
  output logic [1:0]          done_action_o,
  output logic                done_src_o,
  output logic [ADDR_W-1:0]   done_addr_o
);
  logic              idle, grant, i_any, d_any, d_dirty;
  miss_kind_e        kind;
  logic [ADDR_W-1:0] arb_addr;

  smc_miss_arb #(.ADDR_W(ADDR_W)) u_arb (
    .idle_i        (idle),
    .dmiss_valid_i (dmiss_valid_i),
    .dmiss_write_i (dmiss_write_i),
    .dmiss_addr_i  (dmiss_addr_i),
    .imiss_valid_i (imiss_valid_i),
    .imiss_addr_i  (imiss_addr_i),
    .dack_o        (dmiss_ack_o),
    .iack_o        (imiss_ack_o),
    .grant_o       (grant),
    .kind_o        (kind),
    .addr_o        (arb_addr)
  );

  smc_probe_eval #(.N(N_STRUCT)) u_eval (
    .isnp_hit_i (isnp_hit_i),
    .dsnp_hit_i (dsnp_hit_i),
    .dsnp_mod_i (dsnp_mod_i),
    .i_any_o    (i_any),
    .d_any_o    (d_any),
    .d_dirty_o  (d_dirty)
  );

  smc_seq_fsm #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .N(N_STRUCT)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .grant_i         (grant),
    .kind_i          (kind),
    .addr_i          (arb_addr),
    .i_any_i         (i_any),
    .d_any_i         (d_any),
    .d_dirty_i       (d_dirty),
    .isnp_hit_i      (isnp_hit_i),
    .dsnp_hit_i      (dsnp_hit_i),
    .wb_ack_i        (wb_ack_i),
    .wb_data_i       (wb_data_i),
    .idle_o          (idle),
    .probe_i_valid_o (probe_i_valid_o),
    .probe_d_valid_o (probe_d_valid_o),
    .probe_addr_o    (probe_addr_o),
    .ivict_o         (ivict_o),
    .ivict_mask_o    (ivict_mask_o),
    .wb_req_o        (wb_req_o),
    .wb_addr_o       (wb_addr_o),
    .fwd_valid_o     (fwd_valid_o),
    .fwd_addr_o      (fwd_addr_o),
    .fwd_data_o      (fwd_data_o),
    .dinv_o          (dinv_o),
    .dinv_mask_o     (dinv_mask_o),
    .done_o          (done_o),
    .done_action_o   (done_action_o),
    .done_src_o      (done_src_o),
    .done_addr_o     (done_addr_o)
  );
endmodule

// File: rtl/smc_snoop_chk.sv
module smc_snoop_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dmiss_valid_i,
  input logic       dmiss_ack_o,
  input logic       imiss_ack_o,
  input logic       probe_i_valid_o,
  input logic       probe_d_valid_o,
  input logic       ivict_o,
  input logic       wb_req_o,
  input logic       wb_ack_i,
  input logic       fwd_valid_o,
  input logic       dinv_o,
  input logic       done_o,
  input logic [1:0] done_action_o
);
  // R1
  ack_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmiss_ack_o && imiss_ack_o));
  // R1
  dside_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmiss_valid_i |-> !imiss_ack_o);
  // R11
  busy_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_i_valid_o || probe_d_valid_o || wb_req_o) |-> !(dmiss_ack_o || imiss_ack_o));
  // R2
  probe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(probe_i_valid_o && probe_d_valid_o));
  // R4
  ivict_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ivict_o |=> (done_o && done_action_o == 2'd0));
  // R6
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_ack_i) |=> wb_req_o);
  // R6
  fwd_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> $past(wb_req_o && wb_ack_i));
  // R6
  fwd_then_dinv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |=> dinv_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind smc_snoop_ctrl smc_snoop_chk u_chk (.*);

// File: tb/tb_smc_snoop_ctrl.sv
module tb_smc_snoop_ctrl;
  localparam int AW = 32;
  localparam int LW = 256;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          dmiss_valid = 0, dmiss_write = 0, imiss_valid = 0;
  logic [AW-1:0] dmiss_addr = '0, imiss_addr = '0;
  logic [2:0]    isnp_hit = '0, dsnp_hit = '0, dsnp_mod = '0;
  logic          wb_ack = 0;
  logic [LW-1:0] wb_data = '0;
  logic          dmiss_ack, imiss_ack, probe_i_v, probe_d_v, ivict, wb_req, fwd_v, dinv, done, done_src;
  logic [AW-1:0] probe_addr, wb_addr, fwd_addr, done_addr;
  logic [2:0]    ivict_mask, dinv_mask;
  logic [LW-1:0] fwd_data;
  logic [1:0]    done_act;

  smc_snoop_ctrl #(.ADDR_W(AW), .LINE_W(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dmiss_valid_i(dmiss_valid), .dmiss_write_i(dmiss_write), .dmiss_addr_i(dmiss_addr),
    .dmiss_ack_o(dmiss_ack), .imiss_valid_i(imiss_valid), .imiss_addr_i(imiss_addr),
    .imiss_ack_o(imiss_ack), .probe_i_valid_o(probe_i_v), .probe_d_valid_o(probe_d_v),
    .probe_addr_o(probe_addr), .isnp_hit_i(isnp_hit), .dsnp_hit_i(dsnp_hit), .dsnp_mod_i(dsnp_mod),
    .ivict_o(ivict), .ivict_mask_o(ivict_mask), .wb_req_o(wb_req), .wb_addr_o(wb_addr),
    .wb_ack_i(wb_ack), .wb_data_i(wb_data), .fwd_valid_o(fwd_v), .fwd_addr_o(fwd_addr),
    .fwd_data_o(fwd_data), .dinv_o(dinv), .dinv_mask_o(dinv_mask), .done_o(done),
    .done_action_o(done_act), .done_src_o(done_src), .done_addr_o(done_addr)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, wb_lat = 0, wb_wait = 0;
  // event log filled by the monitor
  int pi_cnt, pd_cnt, pi_cyc, pd_cyc, iv_cnt, iv_cyc, wb_cnt, fw_cnt, fw_cyc, di_cnt, di_cyc;
  int dn_cnt, dn_cyc, dn_act, dn_src0, dn_src1;
  logic [AW-1:0] pr_addr, dn_addr, fw_addr;
  logic [2:0]    iv_mask, di_mask;
  logic [LW-1:0] fw_data;

  always @(posedge clk) cyc++;

  task automatic clear_log();
    pi_cnt = 0; pd_cnt = 0; pi_cyc = 0; pd_cyc = 0; iv_cnt = 0; iv_cyc = 0;
    wb_cnt = 0; fw_cnt = 0; fw_cyc = 0; di_cnt = 0; di_cyc = 0;
    dn_cnt = 0; dn_cyc = 0; dn_act = -1; dn_src0 = -1; dn_src1 = -1;
  endtask

  always @(negedge clk) begin
    if (probe_i_v) begin pi_cnt++; pi_cyc = cyc; pr_addr = probe_addr; end
    if (probe_d_v) begin pd_cnt++; pd_cyc = cyc; pr_addr = probe_addr; end
    if (ivict) begin iv_cnt++; iv_cyc = cyc; iv_mask = ivict_mask; end
    if (wb_req) wb_cnt++;
    if (fwd_v) begin fw_cnt++; fw_cyc = cyc; fw_data = fwd_data; fw_addr = fwd_addr; end
    if (dinv) begin di_cnt++; di_cyc = cyc; di_mask = dinv_mask; end
    if (done) begin
      if (dn_cnt == 0) dn_src0 = int'(done_src); else dn_src1 = int'(done_src);
      dn_cnt++; dn_cyc = cyc; dn_act = int'(done_act); dn_addr = done_addr;
    end
  end

  // writeback responder
  always @(negedge clk) begin
    if (wb_req) begin
      if (wb_wait >= wb_lat) wb_ack <= 1'b1;
      else wb_wait <= wb_wait + 1;
    end else begin
      wb_ack  <= 1'b0;
      wb_wait <= 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_d(input logic wr, input logic [AW-1:0] a);
    dmiss_write = wr; dmiss_addr = a; dmiss_valid = 1;
    #1;
    while (!dmiss_ack) begin @(negedge clk); #1; end
    @(negedge clk); dmiss_valid = 0;
  endtask

  task automatic send_i(input logic [AW-1:0] a);
    imiss_addr = a; imiss_valid = 1;
    #1;
    while (!imiss_ack) begin @(negedge clk); #1; end
    @(negedge clk); imiss_valid = 0;
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 200 && dn_cnt < n; k++) begin @(negedge clk); #2; end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R10 done", done, 0);
    chk("R10 probes", {probe_i_v, probe_d_v}, 0);
    chk("R10 actions", {ivict, wb_req, fwd_v, dinv}, 0);
  endtask

  task automatic t_drd_miss();
    clear_log(); isnp_hit = 3'b000;
    @(negedge clk); send_d(0, 32'h1000); wait_done(1);
    chk("R2 iprobe count", pi_cnt, 1);
    chk("R2 no dprobe", pd_cnt, 0);
    chk("R2 probe addr", pr_addr, 32'h1000);
    chk("R8 action", dn_act, 0);
    chk("R8 timing", dn_cyc - pi_cyc, 1);
    chk("R8 no ivict", iv_cnt, 0);
    chk("R9 src", dn_src0, 0);
    chk("R9 addr", dn_addr, 32'h1000);
    @(negedge clk); #1; chk("R9 pulse", done, 0);
  endtask

  task automatic t_drd_hit();
    clear_log(); isnp_hit = 3'b010;
    @(negedge clk); send_d(0, 32'h2040); wait_done(1);
    chk("R3 action", dn_act, 1);
    chk("R3 no ivict", iv_cnt, 0);
    chk("R3 timing", dn_cyc - pi_cyc, 1);
    isnp_hit = 3'b000;
  endtask

  task automatic t_dwr_hit();
    clear_log(); isnp_hit = 3'b101;
    @(negedge clk); send_d(1, 32'h3080); wait_done(1);
    chk("R4 ivict count", iv_cnt, 1);
    chk("R4 ivict mask", iv_mask, 3'b101);
    chk("R4 ivict timing", iv_cyc - pi_cyc, 1);
    chk("R4 done timing", dn_cyc - iv_cyc, 1);
    chk("R4 action", dn_act, 0);
    isnp_hit = 3'b000;
  endtask

  task automatic t_dwr_miss();
    clear_log(); isnp_hit = 3'b000;
    @(negedge clk); send_d(1, 32'h30c0); wait_done(1);
    chk("R8 wr no ivict", iv_cnt, 0);
    chk("R8 wr action", dn_act, 0);
  endtask

  task automatic t_ird_miss();
    clear_log(); dsnp_hit = 3'b000; dsnp_mod = 3'b111; isnp_hit = 3'b111;
    @(negedge clk); send_i(32'h4000); wait_done(1);
    chk("R5 dprobe count", pd_cnt, 1);
    chk("R5 no iprobe", pi_cnt, 0);
    chk("R5 probe addr", pr_addr, 32'h4000);
    chk("R8 i action", dn_act, 0);
    chk("R8 i no side effects", wb_cnt + di_cnt + fw_cnt, 0);
    chk("R9 i src", dn_src0, 1);
    isnp_hit = 3'b000;
  endtask

  task automatic t_ird_clean();
    clear_log(); dsnp_hit = 3'b011; dsnp_mod = 3'b100;
    @(negedge clk); send_i(32'h5100); wait_done(1);
    chk("R7 no wb", wb_cnt, 0);
    chk("R7 dinv mask", di_mask, 3'b011);
    chk("R7 dinv timing", di_cyc - pd_cyc, 1);
    chk("R7 action", dn_act, 2);
    chk("R7 done timing", dn_cyc - di_cyc, 1);
  endtask

  task automatic t_ird_dirty();
    clear_log(); dsnp_hit = 3'b100; dsnp_mod = 3'b100; wb_lat = 3;
    wb_data = {8{32'hC0DE_0000 + 32'h11}};
    @(negedge clk); send_i(32'h6200); wait_done(1);
    chk("R6 wb held", wb_cnt, 4);
    chk("R6 fwd count", fw_cnt, 1);
    chk("R6 fwd data", fw_data[63:0], wb_data[63:0]);
    chk("R6 fwd addr", fw_addr, 32'h6200);
    chk("R6 dinv after fwd", di_cyc - fw_cyc, 1);
    chk("R6 dinv mask", di_mask, 3'b100);
    chk("R6 action", dn_act, 3);
    chk("R6 done timing", dn_cyc - di_cyc, 1);
    wb_lat = 0;
  endtask

  task automatic t_collide();
    int iack_cyc;
    clear_log(); isnp_hit = 3'b000; dsnp_hit = 3'b000; dsnp_mod = 3'b000;
    @(negedge clk);
    dmiss_write = 0; dmiss_addr = 32'h7000; imiss_addr = 32'h7400;
    dmiss_valid = 1; imiss_valid = 1;
    #1;
    chk("R1 dack", dmiss_ack, 1);
    chk("R1 no iack", imiss_ack, 0);
    @(negedge clk); dmiss_valid = 0; #1;
    chk("R11 busy no iack", imiss_ack, 0);
    iack_cyc = -1;
    for (int k = 0; k < 50; k++) begin
      if (imiss_ack) begin iack_cyc = cyc; break; end
      @(negedge clk); #1;
    end
    @(negedge clk); imiss_valid = 0;
    wait_done(2);
    chk("R1 iack after done", iack_cyc > 0 && iack_cyc > pi_cyc + 1, 1);
    chk("R1 first done src", dn_src0, 0);
    chk("R1 second done src", dn_src1, 1);
    chk("R1 done count", dn_cnt, 2);
  endtask

  initial begin
    #(10 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_drd_miss();
    t_drd_hit();
    t_dwr_hit();
    t_dwr_miss();
    t_ird_miss();
    t_ird_clean();
    t_ird_dirty();
    t_collide();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule